// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block performs the state changes a processor makes when it takes an exception. The core's priority logic chooses one exception and presents its kind for one cycle with a request strobe. It also presents the faulting PC, whether that instruction sits in a branch delay slot, whether a TLB miss needs the refill handler, and the coprocessor number for a coprocessor-unusable fault. Alongside these come the current Status, Cause, EBase, EPC, ErrorEPC, DEPC and Debug register values and the user-mode and debug-mode flags.

On the next clock edge the block presents updated copies of all of those registers and flags. In the same edge it raises a one-cycle PC load strobe with the handler address. The core writes the updated values back into its architectural registers and redirects fetch. There are three entry classes: general exceptions use the EBase or boot vector, NMI and soft reset use the error vector, and debug events use the debug vector. Each class saves its return address in a different register.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A request with a kind code of 1 to 25 updates every output and raises `pc_load_o` for exactly one cycle on the clock edge after the strobe. Kind 0 and kinds 26 to 31 are ignored, and so is any cycle without `req_i`: the outputs hold their values and `pc_load_o` stays low.
- R2: General kinds write a 5-bit cause code into `cause_o[6:2]`. Kind to code: 1 interrupt→0, 2 modify→1, 3 TLB load→2, 4 TLB store→3, 5 address load→4, 6 address store→5, 7 instruction bus→6, 8 data bus→7, 9 syscall→8, 10 break→9, 11 reserved instruction→10, 12 coprocessor unusable→11, 13 overflow→12, 14 trap→13, 15 floating point→15, 16 watch→23, 17 machine check→24.
- R3: Kind 12 copies `cop_i` into `cause_o[29:28]`. Every other kind passes those bits through from `cause_i`.
- R4: For general kinds, the vector base is 0xBFC00200 when BEV (`status_i[22]`) is set. Otherwise the base is `ebase_i` with bits 9:0 cleared. `pc_o` is the base plus the offset.
- R5: The offset is 0x000 for a TLB load or TLB store with `refill_i` set and EXL (`status_i[1]`) clear. It is 0x200 for an interrupt with IV (`cause_i[23]`) set. Every other general case uses 0x180, including a refill taken with EXL set.
- R6: A general kind with EXL clear does four things: it writes `epc_o` = PC−4 with BD (`cause_o[31]`) set for a delay-slot instruction, or PC with BD clear otherwise; it sets EXL; and it clears `user_mode_o`.
- R7: A general kind with EXL already set passes EPC, BD and the user-mode flag through unchanged.
- R8: Every accepted kind except single step (kind 20) clears `in_ds_o`. Single step passes `in_ds_i` through.
- R9: NMI (18) and soft reset (19) do the following: write `error_epc_o` with the same delay-slot rule as R6; set ERL (bit 2) and BEV (bit 22); set NMI (bit 19) or SR (bit 20) respectively; clear user mode; clear BD only when EXL is clear; leave EPC and the ExcCode field alone; and load 0xBFC00000.
- R10: Debug kinds do the following: set their bit in `debug_o` (single step 20→bit 0, breakpoint 23→1, data load break 25→2, data store break 24→3, instruction break 22→4, debug interrupt 21→5); write `depc_o` with the R6 delay-slot rule, except that single step always saves PC; set `debug_mode_o`; clear user mode; clear BD only when EXL is clear; and load 0xBFC00480.
- R11: An interrupt (kind 1) requested while `debug_mode_i` is set is taken as a debug interrupt (kind 21).
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Exception request strobe |
| kind_i | input | 5 | Exception kind code |
| pc_i | input | 32 | PC of the faulting instruction |
| in_ds_i | input | 1 | Instruction is in a delay slot |
| refill_i | input | 1 | TLB miss with no matching entry |
| cop_i | input | 2 | Coprocessor number for kind 12 |
| status_i | input | 32 | Current Status |
| cause_i | input | 32 | Current Cause |
| ebase_i | input | 32 | Exception base |
| epc_i | input | 32 | Current EPC |
| error_epc_i | input | 32 | Current ErrorEPC |
| depc_i | input | 32 | Current DEPC |
| debug_i | input | 32 | Current Debug register |
| user_mode_i | input | 1 | Currently in user mode |
| debug_mode_i | input | 1 | Currently in debug mode |
| pc_load_o | output | 1 | One-cycle PC redirect strobe |
| pc_o | output | 32 | Handler address |
| epc_o | output | 32 | Updated EPC |
| error_epc_o | output | 32 | Updated ErrorEPC |
| depc_o | output | 32 | Updated DEPC |
| status_o | output | 32 | Updated Status |
| cause_o | output | 32 | Updated Cause |
| debug_o | output | 32 | Updated Debug register |
| user_mode_o | output | 1 | Updated user-mode flag |
| debug_mode_o | output | 1 | Updated debug-mode flag |
| in_ds_o | output | 1 | Updated delay-slot flag |

## Verification
Every output is registered from the inputs present at the strobe, so a wrong classification, offset or EXL decision shows at the ports on the first edge after the request. The failure takes one of these forms: a wrong handler address, a wrong code field, or a return address in the wrong register. A fault in the hold path shows instead as outputs that drift on cycles with no request or with an unused kind, and it is seen one cycle after that cycle. Random requests over all 32 kind codes are checked against a model of the requirements, with the Status and Cause bits drawn at random. Directed requests then cover refill with EXL set and clear, interrupts with IV set, interrupts in debug mode, and single step in a delay slot.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [4:0] {
    K_NONE = 5'd0,  K_INT  = 5'd1,  K_MOD  = 5'd2,  K_TLBL = 5'd3,
    K_TLBS = 5'd4,  K_ADEL = 5'd5,  K_ADES = 5'd6,  K_IBE  = 5'd7,
    K_DBE  = 5'd8,  K_SYS  = 5'd9,  K_BRK  = 5'd10, K_RI   = 5'd11,
    K_CPU  = 5'd12, K_OV   = 5'd13, K_TRAP = 5'd14, K_FPE  = 5'd15,
    K_WTCH = 5'd16, K_MCHK = 5'd17, K_NMI  = 5'd18, K_SRST = 5'd19,
    K_DSS  = 5'd20, K_DINT = 5'd21, K_DIB  = 5'd22, K_DBP  = 5'd23,
    K_DDBS = 5'd24, K_DDBL = 5'd25
  } exc_kind_e;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_GEN  = 2'd1,
    CLS_ERR  = 2'd2,
    CLS_DBG  = 2'd3
  } exc_class_e;

  // status bit positions
  localparam int unsigned ST_EXL = 1;
  localparam int unsigned ST_ERL = 2;
  localparam int unsigned ST_NMI = 19;
  localparam int unsigned ST_SR  = 20;
  localparam int unsigned ST_BEV = 22;
  // cause bit positions
  localparam int unsigned CA_EC_LO = 2;
  localparam int unsigned CA_IV    = 23;
  localparam int unsigned CA_CE_LO = 28;
  localparam int unsigned CA_BD    = 31;
  // debug bit positions
  localparam int unsigned DB_SSTEP = 0;
  localparam int unsigned DB_BP    = 1;
  localparam int unsigned DB_DLD   = 2;
  localparam int unsigned DB_DST   = 3;
  localparam int unsigned DB_IBRK  = 4;
  localparam int unsigned DB_INT   = 5;
  localparam int unsigned DB_W     = 6;

  localparam logic [XLEN-1:0] VEC_BOOT = 32'hBFC0_0200;
  localparam logic [XLEN-1:0] VEC_ERR  = 32'hBFC0_0000;
  localparam logic [XLEN-1:0] VEC_DBG  = 32'hBFC0_0480;
  localparam logic [XLEN-1:0] OFS_GEN  = 32'h0000_0180;
  localparam logic [XLEN-1:0] OFS_RFL  = 32'h0000_0000;
  localparam logic [XLEN-1:0] OFS_INT  = 32'h0000_0200;
  localparam int unsigned EBASE_LSB = 10;
  localparam logic [XLEN-1:0] INSN_BYTES = 32'd4;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_entry_pkg::*;
(
  input  logic [4:0]        kind_i,
  input  logic              debug_mode_i,
  output exc_class_e        cls_o,
  output logic [CODE_W-1:0] code_o,
  output logic [DB_W-1:0]   dbg_set_o,
  output logic              is_int_o,
  output logic              is_tlb_o,
  output logic              is_cpu_o,
  output logic              is_sstep_o,
  output logic              is_nmi_o
);
  logic [4:0] eff;

  // interrupt while in debug mode becomes a debug interrupt
  always_comb begin
    eff = kind_i;
    if (kind_i == K_INT && debug_mode_i) eff = K_DINT;
  end

  always_comb begin
    cls_o     = CLS_NONE;
    code_o    = '0;
    dbg_set_o = '0;
    unique case (eff)
      K_INT:  begin cls_o = CLS_GEN; code_o = 5'd0;  end
      K_MOD:  begin cls_o = CLS_GEN; code_o = 5'd1;  end
      K_TLBL: begin cls_o = CLS_GEN; code_o = 5'd2;  end
      K_TLBS: begin cls_o = CLS_GEN; code_o = 5'd3;  end
      K_ADEL: begin cls_o = CLS_GEN; code_o = 5'd4;  end
      K_ADES: begin cls_o = CLS_GEN; code_o = 5'd5;  end
      K_IBE:  begin cls_o = CLS_GEN; code_o = 5'd6;  end
      K_DBE:  begin cls_o = CLS_GEN; code_o = 5'd7;  end
      K_SYS:  begin cls_o = CLS_GEN; code_o = 5'd8;  end
      K_BRK:  begin cls_o = CLS_GEN; code_o = 5'd9;  end
      K_RI:   begin cls_o = CLS_GEN; code_o = 5'd10; end
      K_CPU:  begin cls_o = CLS_GEN; code_o = 5'd11; end
      K_OV:   begin cls_o = CLS_GEN; code_o = 5'd12; end
      K_TRAP: begin cls_o = CLS_GEN; code_o = 5'd13; end
      K_FPE:  begin cls_o = CLS_GEN; code_o = 5'd15; end
      K_WTCH: begin cls_o = CLS_GEN; code_o = 5'd23; end
      K_MCHK: begin cls_o = CLS_GEN; code_o = 5'd24; end
      K_NMI, K_SRST: cls_o = CLS_ERR;
      K_DSS:  begin cls_o = CLS_DBG; dbg_set_o[DB_SSTEP] = 1'b1; end
      K_DINT: begin cls_o = CLS_DBG; dbg_set_o[DB_INT]   = 1'b1; end
      K_DIB:  begin cls_o = CLS_DBG; dbg_set_o[DB_IBRK]  = 1'b1; end
      K_DBP:  begin cls_o = CLS_DBG; dbg_set_o[DB_BP]    = 1'b1; end
      K_DDBS: begin cls_o = CLS_DBG; dbg_set_o[DB_DST]   = 1'b1; end
      K_DDBL: begin cls_o = CLS_DBG; dbg_set_o[DB_DLD]   = 1'b1; end
      default: cls_o = CLS_NONE;
    endcase
  end

  assign is_int_o   = (eff == K_INT);
  assign is_tlb_o   = (eff == K_TLBL) || (eff == K_TLBS);
  assign is_cpu_o   = (eff == K_CPU);
  assign is_sstep_o = (eff == K_DSS);
  assign is_nmi_o   = (eff == K_NMI);
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  exc_class_e    cls_i,
  input  logic          is_int_i,
  input  logic          is_tlb_i,
  input  logic          refill_i,
  input  logic          exl_i,
  input  logic          bev_i,
  input  logic          iv_i,
  input  logic [AW-1:0] ebase_i,
  output logic [AW-1:0] vec_o
);
  logic [AW-1:0] base;
  logic [AW-1:0] ofs;

  always_comb begin
    if (bev_i) base = VEC_BOOT;
    else       base = {ebase_i[AW-1:EBASE_LSB], {EBASE_LSB{1'b0}}};
  end

  always_comb begin
    if (is_tlb_i && refill_i && !exl_i) ofs = OFS_RFL;
    else if (is_int_i && iv_i)          ofs = OFS_INT;
    else                                ofs = OFS_GEN;
  end

  always_comb begin
    unique case (cls_i)
      CLS_ERR: vec_o = VEC_ERR;
      CLS_DBG: vec_o = VEC_DBG;
      default: vec_o = base + ofs;
    endcase
  end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr
  import exc_entry_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  logic [AW-1:0] pc_i,
  input  logic          in_ds_i,
  input  logic          force_pc_i,
  output logic [AW-1:0] ret_o
);
  // delay slot: resume at the branch
  assign ret_o = (in_ds_i && !force_pc_i) ? pc_i - INSN_BYTES : pc_i;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int unsigned AW = XLEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [4:0]    kind_i,
  input  logic [AW-1:0] pc_i,
  input  logic          in_ds_i,
  input  logic          refill_i,
  input  logic [1:0]    cop_i,
  input  logic [31:0]   status_i,
  input  logic [31:0]   cause_i,
  input  logic [AW-1:0] ebase_i,
  input  logic [AW-1:0] epc_i,
  input  logic [AW-1:0] error_epc_i,
  input  logic [AW-1:0] depc_i,
  input  logic [31:0]   debug_i,
  input  logic          user_mode_i,
  input  logic          debug_mode_i,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] epc_o,
  output logic [AW-1:0] error_epc_o,
  output logic [AW-1:0] depc_o,
  output logic [31:0]   status_o,
  output logic [31:0]   cause_o,
  output logic [31:0]   debug_o,
  output logic          user_mode_o,
  output logic          debug_mode_o,
  output logic          in_ds_o
);
  exc_class_e        cls;
  logic [CODE_W-1:0] code;
  logic [DB_W-1:0]   dbg_set;
  logic              is_int, is_tlb, is_cpu, is_sstep, is_nmi;
  logic [AW-1:0]     vec, ret;
  logic              exl;
  logic              take;

  assign exl  = status_i[ST_EXL];
  assign take = req_i && (cls != CLS_NONE);

  exc_classify u_cls (
    .kind_i      (kind_i),
    .debug_mode_i(debug_mode_i),
    .cls_o       (cls),
    .code_o      (code),
    .dbg_set_o   (dbg_set),
    .is_int_o    (is_int),
    .is_tlb_o    (is_tlb),
    .is_cpu_o    (is_cpu),
    .is_sstep_o  (is_sstep),
    .is_nmi_o    (is_nmi)
  );

  exc_vector_sel #(.AW(AW)) u_vec (
    .cls_i   (cls),
    .is_int_i(is_int),
    .is_tlb_i(is_tlb),
    .refill_i(refill_i),
    .exl_i   (exl),
    .bev_i   (status_i[ST_BEV]),
    .iv_i    (cause_i[CA_IV]),
    .ebase_i (ebase_i),
    .vec_o   (vec)
  );

  exc_ret_addr #(.AW(AW)) u_ret (
    .pc_i      (pc_i),
    .in_ds_i   (in_ds_i),
    .force_pc_i(is_sstep),
    .ret_o     (ret)
  );

  logic [AW-1:0] n_epc, n_eepc, n_depc;
  logic [31:0]   n_status, n_cause, n_debug;
  logic          n_user, n_dmode, n_ds;

  always_comb begin
    n_epc    = epc_i;
    n_eepc   = error_epc_i;
    n_depc   = depc_i;
    n_status = status_i;
    n_cause  = cause_i;
    n_debug  = debug_i;
    n_user   = user_mode_i;
    n_dmode  = debug_mode_i;
    n_ds     = 1'b0;
    unique case (cls)
      CLS_GEN: begin
        if (!exl) begin
          n_epc            = ret;
          n_cause[CA_BD]   = in_ds_i;
          n_status[ST_EXL] = 1'b1;
          n_user           = 1'b0;
        end
        n_cause[CA_EC_LO +: CODE_W] = code;
        if (is_cpu) n_cause[CA_CE_LO +: 2] = cop_i;
      end
      CLS_ERR: begin
        n_eepc           = ret;
        n_status[ST_ERL] = 1'b1;
        n_status[ST_BEV] = 1'b1;
        if (is_nmi) n_status[ST_NMI] = 1'b1;
        else        n_status[ST_SR]  = 1'b1;
        n_user = 1'b0;
        if (!exl) n_cause[CA_BD] = 1'b0;
      end
      CLS_DBG: begin
        n_depc            = ret;
        n_debug[DB_W-1:0] = debug_i[DB_W-1:0] | dbg_set;
        n_dmode           = 1'b1;
        n_user            = 1'b0;
        if (!exl) n_cause[CA_BD] = 1'b0;
        if (is_sstep) n_ds = in_ds_i;
      end
      default: n_ds = in_ds_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_load_o    <= 1'b0;
      pc_o         <= '0;
      epc_o        <= '0;
      error_epc_o  <= '0;
      depc_o       <= '0;
      status_o     <= '0;
      cause_o      <= '0;
      debug_o      <= '0;
      user_mode_o  <= 1'b0;
      debug_mode_o <= 1'b0;
      in_ds_o      <= 1'b0;
    end else begin
      pc_load_o <= take;
      if (take) begin
        pc_o         <= vec;
        epc_o        <= n_epc;
        error_epc_o  <= n_eepc;
        depc_o       <= n_depc;
        status_o     <= n_status;
        cause_o      <= n_cause;
        debug_o      <= n_debug;
        user_mode_o  <= n_user;
        debug_mode_o <= n_dmode;
        in_ds_o      <= n_ds;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_entry_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic [4:0]  kind_i,
  input logic [31:0] status_i,
  input logic [31:0] cause_i,
  input logic [31:0] epc_i,
  input logic        debug_mode_i,
  input logic        pc_load_o,
  input logic [31:0] pc_o,
  input logic [31:0] epc_o,
  input logic [31:0] status_o,
  input logic [31:0] cause_o,
  input logic [31:0] debug_o,
  input logic        user_mode_o,
  input logic        debug_mode_o
);
  logic valid_k, gen_k, err_k, dbg_k;
  assign valid_k = (kind_i >= 5'd1) && (kind_i <= 5'd25);
  assign gen_k   = (kind_i >= 5'd1) && (kind_i <= 5'd17) && !(kind_i == 5'd1 && debug_mode_i);
  assign err_k   = (kind_i == 5'd18) || (kind_i == 5'd19);
  assign dbg_k   = (kind_i >= 5'd20) && (kind_i <= 5'd25);

  p_load_after_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && valid_k |=> pc_load_o);
  p_no_spurious_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && valid_k) |=> !pc_load_o);
  p_kernel_after_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && valid_k && !(gen_k && status_i[ST_EXL]) |=> !user_mode_o && pc_load_o);
  p_epc_kept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && gen_k && status_i[ST_EXL] |=> epc_o == $past(epc_i) && cause_o[CA_BD] == $past(cause_i[CA_BD]));
  p_vec_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> pc_o[6:0] == 7'd0);
  p_err_vector_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && err_k |=> pc_o == VEC_ERR && status_o[ST_ERL] && status_o[ST_BEV]);
  p_dbg_vector_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && dbg_k |=> pc_o == VEC_DBG && debug_mode_o);
  p_int_in_dbg_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && kind_i == 5'd1 && debug_mode_i |=> debug_o[DB_INT] && pc_o == VEC_DBG);
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .kind_i      (kind_i),
  .status_i    (status_i),
  .cause_i     (cause_i),
  .epc_i       (epc_i),
  .debug_mode_i(debug_mode_i),
  .pc_load_o   (pc_load_o),
  .pc_o        (pc_o),
  .epc_o       (epc_o),
  .status_o    (status_o),
  .cause_o     (cause_o),
  .debug_o     (debug_o),
  .user_mode_o (user_mode_o),
  .debug_mode_o(debug_mode_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [4:0]  kind = '0;
  logic [31:0] pc = '0, status = '0, cause = '0, ebase = '0;
  logic [31:0] epc = '0, eepc = '0, depc = '0, dbg = '0;
  logic        in_ds = 1'b0, refill = 1'b0, umode = 1'b0, dmode = 1'b0;
  logic [1:0]  cop = '0;

  logic        pc_load;
  logic [31:0] pc_out, epc_out, eepc_out, depc_out, status_out, cause_out, dbg_out;
  logic        umode_out, dmode_out, ds_out;

  int total = 0;
  int bad = 0;

  // expected state
  logic        e_load;
  logic [31:0] e_pc, e_epc, e_eepc, e_depc, e_status, e_cause, e_dbg;
  logic        e_umode, e_dmode, e_ds;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .kind_i(kind), .pc_i(pc),
    .in_ds_i(in_ds), .refill_i(refill), .cop_i(cop), .status_i(status),
    .cause_i(cause), .ebase_i(ebase), .epc_i(epc), .error_epc_i(eepc),
    .depc_i(depc), .debug_i(dbg), .user_mode_i(umode), .debug_mode_i(dmode),
    .pc_load_o(pc_load), .pc_o(pc_out), .epc_o(epc_out), .error_epc_o(eepc_out),
    .depc_o(depc_out), .status_o(status_out), .cause_o(cause_out),
    .debug_o(dbg_out), .user_mode_o(umode_out), .debug_mode_o(dmode_out),
    .in_ds_o(ds_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] code_of(input int k);
    case (k)
      1: return 5'd0;   2: return 5'd1;   3: return 5'd2;   4: return 5'd3;
      5: return 5'd4;   6: return 5'd5;   7: return 5'd6;   8: return 5'd7;
      9: return 5'd8;   10: return 5'd9;  11: return 5'd10; 12: return 5'd11;
      13: return 5'd12; 14: return 5'd13; 15: return 5'd15; 16: return 5'd23;
      default: return 5'd24;
    endcase
  endfunction

  function automatic int dbit_of(input int k);
    case (k)
      20: return 0; 23: return 1; 25: return 2; 24: return 3; 22: return 4;
      default: return 5;
    endcase
  endfunction

  // expected outputs from the requirements
  task automatic model();
    int k;
    logic exl;
    logic [31:0] ret, base, ofs;
    k = int'(kind);
    if (!req || k == 0 || k > 25) begin e_load = 1'b0; return; end
    if (k == 1 && dmode) k = 21;                         // R11
    exl = status[1];
    ret = in_ds ? pc - 32'd4 : pc;
    e_load = 1'b1; e_epc = epc; e_eepc = eepc; e_depc = depc;
    e_status = status; e_cause = cause; e_dbg = dbg;
    e_umode = umode; e_dmode = dmode; e_ds = 1'b0;
    if (k <= 17) begin
      if (!exl) begin
        e_epc = ret; e_cause[31] = in_ds; e_status[1] = 1'b1; e_umode = 1'b0;
      end
      e_cause[6:2] = code_of(k);
      if (k == 12) e_cause[29:28] = cop;
      base = status[22] ? 32'hBFC00200 : (ebase & 32'hFFFFFC00);
      if ((k == 3 || k == 4) && refill && !exl) ofs = 32'h0;
      else if (k == 1 && cause[23])             ofs = 32'h200;
      else                                      ofs = 32'h180;
      e_pc = base + ofs;
    end else if (k <= 19) begin
      e_eepc = ret; e_status[2] = 1'b1; e_status[22] = 1'b1;
      if (k == 18) e_status[19] = 1'b1; else e_status[20] = 1'b1;
      e_umode = 1'b0;
      if (!exl) e_cause[31] = 1'b0;
      e_pc = 32'hBFC00000;
    end else begin
      e_depc = (k == 20) ? pc : ret;
      e_dbg[dbit_of(k)] = 1'b1;
      e_dmode = 1'b1; e_umode = 1'b0;
      if (!exl) e_cause[31] = 1'b0;
      if (k == 20) e_ds = in_ds;
      e_pc = 32'hBFC00480;
    end
  endtask

  task automatic check_all();
    chk("R1 load", {31'd0, pc_load}, {31'd0, e_load});
    chk("R4/R5 pc", pc_out, e_pc);
    chk("R6/R7 epc", epc_out, e_epc);
    chk("R9 error_epc", eepc_out, e_eepc);
    chk("R10 depc", depc_out, e_depc);
    chk("R6/R9 status", status_out, e_status);
    chk("R2/R3 cause", cause_out, e_cause);
    chk("R10 debug", dbg_out, e_dbg);
    chk("R6 user", {31'd0, umode_out}, {31'd0, e_umode});
    chk("R10 dmode", {31'd0, dmode_out}, {31'd0, e_dmode});
    chk("R8 ds", {31'd0, ds_out}, {31'd0, e_ds});
  endtask

  task automatic randomize_ctx();
    pc = $urandom() & 32'hFFFFFFFC; status = $urandom(); cause = $urandom();
    ebase = $urandom(); epc = $urandom(); eepc = $urandom(); depc = $urandom();
    dbg = $urandom() & 32'hFFFFFFC0;
    in_ds = 1'($urandom()); refill = 1'($urandom()); cop = 2'($urandom());
    umode = 1'($urandom()); dmode = ($urandom_range(0, 3) == 0);
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input logic r, input logic [4:0] k);
    req = r; kind = k;
    model();
    @(negedge clk);
    req = 1'b0;
    check_all();
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    e_load = 0; e_pc = 0; e_epc = 0; e_eepc = 0; e_depc = 0; e_status = 0;
    e_cause = 0; e_dbg = 0; e_umode = 0; e_dmode = 0; e_ds = 0;
    repeat (3) @(negedge clk);
    check_all();                                        // R12 reset state
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    // R5: refill with EXL clear -> 0x000 offset
    randomize_ctx(); status[1] = 0; status[22] = 0; refill = 1; dmode = 0; ebase = 32'h8000_1234;
    step(1'b1, 5'd3);
    chk("R5 refill ofs", pc_out, 32'h8000_1000);
    // R5: refill with EXL set -> 0x180; R7 epc kept
    randomize_ctx(); status[1] = 1; status[22] = 0; refill = 1; dmode = 0; ebase = 32'h8000_0000;
    step(1'b1, 5'd4);
    chk("R5 refill exl", pc_out, 32'h8000_0180);
    chk("R7 epc kept", epc_out, epc);
    // R5: interrupt with IV, BEV set (R4)
    randomize_ctx(); status[1] = 0; status[22] = 1; cause[23] = 1; dmode = 0;
    step(1'b1, 5'd1);
    chk("R5 iv ofs", pc_out, 32'hBFC00400);
    // R3: coprocessor number into CE
    randomize_ctx(); cop = 2'd2; dmode = 0;
    step(1'b1, 5'd12);
    chk("R3 ce", {30'd0, cause_out[29:28]}, 32'd2);
    // R11: interrupt in debug mode
    randomize_ctx(); dmode = 1;
    step(1'b1, 5'd1);
    chk("R11 dint bit", {31'd0, dbg_out[5]}, 32'd1);
    // R10: single step in delay slot saves PC
    randomize_ctx(); in_ds = 1; dmode = 0;
    step(1'b1, 5'd20);
    chk("R10 sstep depc", depc_out, pc);
    chk("R8 sstep ds", {31'd0, ds_out}, 32'd1);
    // R9: NMI in delay slot
    randomize_ctx(); in_ds = 1; status[1] = 0;
    step(1'b1, 5'd18);
    chk("R9 nmi eepc", eepc_out, pc - 32'd4);
    // R1: ignored kinds and idle cycles hold outputs
    randomize_ctx(); step(1'b1, 5'd0);
    randomize_ctx(); step(1'b1, 5'd30);
    randomize_ctx(); step(1'b0, 5'd5);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      randomize_ctx();
      step(($urandom_range(0, 7) != 0), 5'($urandom_range(0, 31)));
      if ($urandom_range(0, 3) == 0) begin
        req = 1'b0; model(); @(negedge clk); check_all();
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule